// File: doc/BRIEF.md
# Dual-Input Up/Down Cascadable Counter

This block is a four-bit binary counter driven by two separate count strobes instead of a clock plus a direction select. A rising edge on the increment strobe steps the count up and a rising edge on the decrement strobe steps it down, each only while the other strobe rests high. Both strobes are asynchronous to the block. They pass through a synchronizer on the system clock, and their rising edges are found there. All state bits change on the same clock edge, so the count output never shows an intermediate value.

A parallel preset loads the data inputs while its active-low control is held. A clear, active high, forces the count to zero and overrides the preset and both strobes. Two active-low cascade flags are provided. The carry flag is low while the count is at its maximum and the increment strobe is low. The borrow flag is low while the count is zero and the decrement strobe is low. When the strobe returns high, the flag returns high on the same clock edge. A downstream stage can take the flags straight onto its own strobe inputs, so wider counters need no glue logic. Feeding the borrow flag back into the preset control turns the block into a divide-by-N.

Top module: `updn_strobe_counter`

## Requirements
- R1: After the system reset is released, the count is 0 and both cascade flags are high (inactive).
- R2: A rising edge on `inc_stb`, while `dec_stb` is high, increments the count by one. The count wraps from 15 to 0. The new value appears within three clock edges of the strobe's rise.
- R3: A rising edge on `dec_stb`, while `inc_stb` is high, decrements the count by one. The count wraps from 0 to 15, with the same latency as R2.
- R4: A rising edge on either strobe while the other strobe is low leaves the count unchanged.
- R5: While `load_n` is low and `clr` is low, the count takes `din` on each clock edge, and any strobe edge in those cycles is discarded.
- R6: While `clr` is high, the count is 0 on the next clock edge, whatever `load_n`, `din` and the strobes do.
- R7: `carry_n` is low exactly when the count is 15 and the synchronized `inc_stb` is low. `borrow_n` is low exactly when the count is 0 and the synchronized `dec_stb` is low.
- R8: When qualifying edges on both strobes are detected in the same clock cycle, the count holds.
- R9: When a second stage takes `carry_n` on its increment strobe and `borrow_n` on its decrement strobe, the two stages count as one 8-bit counter in both directions, including wrap across the stage boundary.
- R10: With `borrow_n` tied to `load_n` and `din` = N, the block emits one `borrow_n` pulse for every N decrement edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| inc_stb | input | 1 | Count-up strobe; acts on its rising edge, idles high |
| dec_stb | input | 1 | Count-down strobe; acts on its rising edge, idles high |
| load_n | input | 1 | Active-low parallel preset |
| clr | input | 1 | Active-high clear, highest priority |
| din | input | 4 | Preset value |
| cnt | output | 4 | Current count |
| carry_n | output | 1 | Active-low carry: count at maximum and up strobe low |
| borrow_n | output | 1 | Active-low borrow: count at zero and down strobe low |

## Verification
A corrupted count register shows on `cnt` at the next sampled point and stays wrong, because every later step builds on it. A wrong edge detector shows as a missing step, a double step or a spurious step three clock edges after a strobe change. Faulty flag logic shows while a strobe is held low at an end value. In the cascaded and divide-by-N arrangements it also shows as a wrong upper byte, or as a borrow pulse at the wrong strobe count, within a few cycles.

// File: rtl/updn_pkg.sv
package updn_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_INC  = 2'b01,
      STEP_DEC  = 2'b10
   } step_e;

endpackage

// File: rtl/updn_strobe_sync.sv
module updn_strobe_sync #(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic lvl_o,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("updn_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE}};
         prev_q  <= IDLE;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = lvl_o & ~prev_q;

   // R2
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
   import updn_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             load_n_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             up_rise_i,
   input  logic             up_lvl_i,
   input  logic             dn_rise_i,
   input  logic             dn_lvl_i,
   output logic [WIDTH-1:0] cnt_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   step_e            step;
   logic [WIDTH-1:0] cnt_q;
   logic             inc_ok;
   logic             dec_ok;

   assign inc_ok = up_rise_i & dn_lvl_i;
   assign dec_ok = dn_rise_i & up_lvl_i;

   always_comb begin
      unique case ({dec_ok, inc_ok})
         2'b01:   step = STEP_INC;
         2'b10:   step = STEP_DEC;
         default: step = STEP_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (!load_n_i) begin
         cnt_q <= din_i;
      end else begin
         case (step)
            STEP_INC: cnt_q <= cnt_q + ONE;
            STEP_DEC: cnt_q <= cnt_q - ONE;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt_o = cnt_q;

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));

   // R5
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !load_n_i) |=> (cnt_o == $past(din_i)));

   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == 1'b0 && load_n_i && up_rise_i && dn_lvl_i && !dn_rise_i)
      |=> (cnt_o == $past(cnt_o) + ONE));

   // R3
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == 1'b0 && load_n_i && dn_rise_i && up_lvl_i && !up_rise_i)
      |=> (cnt_o == $past(cnt_o) - ONE));

   // R8
   both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && load_n_i && up_rise_i && dn_rise_i) |=> $stable(cnt_o));

   // R4
   no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && load_n_i && !(up_rise_i && dn_lvl_i) && !(dn_rise_i && up_lvl_i))
      |=> $stable(cnt_o));

endmodule

// File: rtl/updn_cascade_flags.sv
module updn_cascade_flags #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cnt_i,
   input  logic             up_lvl_i,
   input  logic             dn_lvl_i,
   output logic             carry_n_o,
   output logic             borrow_n_o
);

   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

   logic at_top;
   logic at_zero;

   assign at_top     = (cnt_i == TOP_VAL);
   assign at_zero    = (cnt_i == '0);
   assign carry_n_o  = ~(at_top  & ~up_lvl_i);
   assign borrow_n_o = ~(at_zero & ~dn_lvl_i);

   // R7
   carry_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carry_n_o) |-> ($rose(up_lvl_i) || !$stable(cnt_i)));

   // R7
   borrow_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(borrow_n_o) |-> ($rose(dn_lvl_i) || !$stable(cnt_i)));

   // R7
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(carry_n_o == 1'b0 && borrow_n_o == 1'b0));

endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter #(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_stb,
   input  logic             dec_stb,
   input  logic             load_n,
   input  logic             clr,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cnt,
   output logic             carry_n,
   output logic             borrow_n
);

   if (WIDTH < 2) begin : g_bad_width
      $error("updn_strobe_counter: WIDTH must be at least 2");
   end

   localparam int N_STB = 2;

   logic [N_STB-1:0] stb_raw;
   logic [N_STB-1:0] stb_lvl;
   logic [N_STB-1:0] stb_rise;

   assign stb_raw = {dec_stb, inc_stb};

   for (genvar g = 0; g < N_STB; g++) begin : g_sync
      updn_strobe_sync #(
         .STAGES (SYNC_STAGES),
         .IDLE   (1'b1)
      ) i_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (stb_raw[g]),
         .lvl_o  (stb_lvl[g]),
         .rise_o (stb_rise[g])
      );
   end

   updn_count_core #(
      .WIDTH (WIDTH)
   ) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .load_n_i  (load_n),
      .din_i     (din),
      .up_rise_i (stb_rise[0]),
      .up_lvl_i  (stb_lvl[0]),
      .dn_rise_i (stb_rise[1]),
      .dn_lvl_i  (stb_lvl[1]),
      .cnt_o     (cnt)
   );

   updn_cascade_flags #(
      .WIDTH (WIDTH)
   ) i_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_i      (cnt),
      .up_lvl_i   (stb_lvl[0]),
      .dn_lvl_i   (stb_lvl[1]),
      .carry_n_o  (carry_n),
      .borrow_n_o (borrow_n)
   );

   // R7
   carry_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> (cnt == {WIDTH{1'b1}}));

   // R7
   borrow_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (cnt == '0));

endmodule

// File: tb/test_updn_strobe_counter.sv
module test_updn_strobe_counter;

   localparam int W    = 4;
   localparam int DIVN = 6;

   localparam logic [1:0] OP_UP = 2'd0;
   localparam logic [1:0] OP_DN = 2'd1;
   localparam logic [1:0] OP_LD = 2'd2;
   localparam logic [1:0] OP_CL = 2'd3;

   // {op, din, expected count}
   localparam int NVEC = 14;
   localparam logic [9:0] VEC [0:NVEC-1] = '{
      {OP_CL, 4'd0,  4'd0},
      {OP_UP, 4'd0,  4'd1},
      {OP_UP, 4'd0,  4'd2},
      {OP_DN, 4'd0,  4'd1},
      {OP_DN, 4'd0,  4'd0},
      {OP_DN, 4'd0,  4'd15},
      {OP_UP, 4'd0,  4'd0},
      {OP_LD, 4'd9,  4'd9},
      {OP_UP, 4'd0,  4'd10},
      {OP_DN, 4'd0,  4'd9},
      {OP_LD, 4'd15, 4'd15},
      {OP_UP, 4'd0,  4'd0},
      {OP_CL, 4'd0,  4'd0},
      {OP_DN, 4'd0,  4'd15}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         up = 1'b1, dn = 1'b1, ld_n = 1'b1, clr = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] cnt, cnt_hi, cnt_div;
   logic         co, bo, co_hi, bo_hi, co_div, bo_div;
   logic         dv_dn = 1'b1;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   updn_strobe_counter i_updn_strobe_counter (
      .clk(clk), .rst_n(rst_n), .inc_stb(up), .dec_stb(dn), .load_n(ld_n),
      .clr(clr), .din(din), .cnt(cnt), .carry_n(co), .borrow_n(bo));

   updn_strobe_counter i_updn_strobe_counter_hi (
      .clk(clk), .rst_n(rst_n), .inc_stb(co), .dec_stb(bo), .load_n(1'b1),
      .clr(clr), .din(din), .cnt(cnt_hi), .carry_n(co_hi), .borrow_n(bo_hi));

   updn_strobe_counter i_updn_strobe_counter_div (
      .clk(clk), .rst_n(rst_n), .inc_stb(1'b1), .dec_stb(dv_dn), .load_n(bo_div),
      .clr(1'b0), .din(4'(DIVN)), .cnt(cnt_div), .carry_n(co_div), .borrow_n(bo_div));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_up();
      up = 1'b0; ticks(3); up = 1'b1; ticks(6);
   endtask

   task automatic pulse_dn();
      dn = 1'b0; ticks(3); dn = 1'b1; ticks(6);
   endtask

   task automatic apply(input logic [1:0] op, input logic [W-1:0] d);
      case (op)
         OP_UP: pulse_up();
         OP_DN: pulse_dn();
         OP_LD: begin din = d; ld_n = 1'b0; ticks(1); ld_n = 1'b1; ticks(1); end
         default: begin clr = 1'b1; ticks(1); clr = 1'b0; ticks(1); end
      endcase
   endtask

   task automatic run();
      logic seen;
      ticks(3);
      rst_n = 1'b1;
      ticks(1);
      // R1
      check("R1 count", cnt, 0);
      check("R1 carry_n", co, 1);
      check("R1 borrow_n", bo, 1);

      // table walk: R2 R3 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         apply(VEC[v][9:8], VEC[v][7:4]);
         check("R2/R3/R5/R6 vector", cnt, VEC[v][3:0]);
      end

      // R4: up edge ignored while down held low, and vice versa
      apply(OP_LD, 4'd7);
      dn = 1'b0; ticks(3);
      pulse_up();
      check("R4 up while down low", cnt, 7);
      dn = 1'b1; ticks(6);
      check("R4 down rise while up idle", cnt, 6);
      up = 1'b0; ticks(3);
      pulse_dn();
      check("R4 down while up low", cnt, 6);
      up = 1'b1; ticks(6);
      check("R4 up rise after", cnt, 7);

      // R8: both strobes rise together
      up = 1'b0; dn = 1'b0; ticks(4);
      up = 1'b1; dn = 1'b1; ticks(6);
      check("R8 simultaneous hold", cnt, 7);

      // R5: load held across an up edge discards the edge
      up = 1'b0; ticks(3);
      din = 4'd3; ld_n = 1'b0; up = 1'b1; ticks(5);
      ld_n = 1'b1; ticks(4);
      check("R5 load beats edge", cnt, 3);

      // R6: clear beats load
      din = 4'd11; ld_n = 1'b0; clr = 1'b1; ticks(2);
      check("R6 clear over load", cnt, 0);
      ld_n = 1'b1; clr = 1'b0; ticks(1);

      // R7: carry and borrow
      apply(OP_LD, 4'd15);
      up = 1'b0; ticks(3);
      check("R7 carry low at 15", co, 0);
      check("R7 borrow high at 15", bo, 1);
      up = 1'b1; ticks(2);
      check("R7 carry released", co, 1);
      ticks(4);
      dn = 1'b0; ticks(3);
      check("R7 borrow low at 0", bo, 0);
      check("R7 carry high at 0", co, 1);
      dn = 1'b1; ticks(6);
      check("R7 wrap down", cnt, 15);

      // R9: cascade as 8 bits
      apply(OP_CL, 4'd0);
      for (int k = 1; k <= 40; k++) begin
         pulse_up();
         check("R9 cascade up", {cnt_hi, cnt}, k);
      end
      for (int k = 1; k <= 45; k++) begin
         pulse_dn();
         check("R9 cascade down", {cnt_hi, cnt}, (40 - k) & 8'hFF);
      end

      // R10: divide-by-N
      dv_dn = 1'b0; ticks(3); dv_dn = 1'b1; ticks(6);
      check("R10 first reload", cnt_div, DIVN - 1);
      for (int k = 1; k <= 3 * DIVN; k++) begin
         seen = 1'b0;
         dv_dn = 1'b0;
         for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            if (!bo_div) seen = 1'b1;
         end
         dv_dn = 1'b1; ticks(6);
         check("R10 borrow period", seen, (k % DIVN) == 0);
      end
   endtask

   initial begin
      fork
         run();
         begin
            ticks(150000);
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule